// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit in-order integer core with five stages: fetch, register read, ALU, memory access and register writeback. It decodes a small load/store instruction subset: load upper immediate, OR immediate, add immediate without overflow trap, register AND, word load, word store, branch-if-not-equal and jump-to-register. A new instruction is fetched every cycle. There are no hardware interlocks, no stalls and no flushes.

The instruction after a branch or jump always executes. The only path from a result to a later reader goes through the register file, which passes a value being written back straight to a read in the same cycle. Software must therefore place a producer at least three instructions ahead of any consumer and fill every delay slot. The block fetches from an instruction memory and accesses a data memory. Both memories answer within the same cycle. A debug read port shows the committed contents of any register.

Top module: `p5_core`

## Requirements
- R1: Each stage takes one cycle. An instruction fetched in the first cycle after reset shows its result on the debug port after the fifth rising edge and not after the fourth.
- R2: After reset the fetch address is 0. It grows by 4 every cycle unless a branch or jump redirects it.
- R3: Register 0 always reads as zero. Writes that name it leave it zero.
- R4: Opcode 0x0F places imm[15:0] in bits 31:16 of rt and clears bits 15:0. Opcode 0x0D ORs the zero-extended immediate into rs and writes rt. Together the two build any 32-bit constant.
- R5: Opcode 0x09 adds the sign-extended immediate to rs and writes rt, wrapping modulo 2^32 with no trap. R-type (opcode 0x00, bits 10:6 zero) with funct 0x24 writes rs AND rt into rd (bits 15:11).
- R6: Opcode 0x23 (load) and opcode 0x2B (store) address data memory at rs plus the sign-extended offset. A store drives the write strobe, the address and rt as write data during its memory-stage cycle. A load writes the returned word into rt.
- R7: Opcode 0x05 branches when rs differs from rt. The target is the address of the delay slot plus the sign-extended offset times 4. When rs equals rt, fetch continues in sequence.
- R8: R-type with funct 0x08 jumps to the address held in rs.
- R9: The instruction right after a branch or jump always executes, whether or not the branch is taken.
- R10: A value is seen by a reader three instructions later, through the write-to-read pass in the register file. Readers one or two instructions later see the old value.
- R11: The all-zero word and any encoding outside the listed set behave as no operation.
- R12: Synchronous reset sets the fetch address to 0, empties every stage, clears all registers and holds the data write strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the load or store in the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; memory writes on the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Committed value of register dbg_sel |

## Verification
The assertions assume that reset is held for at least one edge before the first instruction is fetched. They also assume that both memories return data in the cycle they are addressed, so every fetched word and load result is a known value. The bench models both memories as arrays read without delay and holds reset at the start. It keeps every producer at least three slots ahead of its consumer, except for the pair of deliberate early reads that test R10. Every branch and jump in the bench program therefore sees settled register values.

// File: rtl/p5_pkg.sv
package p5_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned REG_AW = 5;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_BNE   = 6'h05;
    localparam logic [5:0] OPC_ADDIU = 6'h09;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LUI   = 6'h0F;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] FN_JR     = 6'h08;
    localparam logic [5:0] FN_AND    = 6'h24;

    typedef enum logic [3:0] {
        K_NOP, K_LUI, K_ORI, K_ADDIU, K_AND, K_LW, K_SW, K_BNE, K_JR
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [REG_AW-1:0]   rs;
        logic [REG_AW-1:0]   rt;
        logic [REG_AW-1:0]   dest;
        logic                wen;
        logic [XLEN-1:0]     imm;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] pc4;
    } fd_t;

    typedef struct packed {
        kind_e             kind;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
        logic [XLEN-1:0]   imm;
        logic [REG_AW-1:0] dest;
        logic              wen;
    } dx_t;

    typedef struct packed {
        kind_e             kind;
        logic [XLEN-1:0]   res;
        logic [XLEN-1:0]   sdata;
        logic [REG_AW-1:0] dest;
        logic              wen;
    } xm_t;

    typedef struct packed {
        logic [XLEN-1:0]   data;
        logic [REG_AW-1:0] dest;
        logic              wen;
    } mw_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        fd_t             fd;
        dx_t             dx;
        xm_t             xm;
        mw_t             mw;
    } pipe_t;

endpackage

// File: rtl/p5_decode.sv
module p5_decode
    import p5_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    localparam int unsigned IMM_W = 16;

    logic [5:0]       opc;
    logic [5:0]       fn;
    logic [IMM_W-1:0] imm16;

    always_comb begin
        opc   = instr[31:26];
        fn    = instr[5:0];
        imm16 = instr[IMM_W-1:0];
        dec      = '0;
        dec.kind = K_NOP;
        dec.rs   = instr[25:21];
        dec.rt   = instr[20:16];
        dec.dest = instr[20:16];
        dec.imm  = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
        case (opc)
            OPC_LUI: begin
                dec.kind = K_LUI;
                dec.wen  = 1'b1;
                dec.imm  = {imm16, {(XLEN-IMM_W){1'b0}}};
            end
            OPC_ORI: begin
                dec.kind = K_ORI;
                dec.wen  = 1'b1;
                dec.imm  = {{(XLEN-IMM_W){1'b0}}, imm16};
            end
            OPC_ADDIU: begin
                dec.kind = K_ADDIU;
                dec.wen  = 1'b1;
            end
            OPC_LW: begin
                dec.kind = K_LW;
                dec.wen  = 1'b1;
            end
            OPC_SW:  dec.kind = K_SW;
            OPC_BNE: dec.kind = K_BNE;
            OPC_RTYPE: begin
                if (instr[10:6] == '0 && fn == FN_AND) begin
                    dec.kind = K_AND;
                    dec.wen  = 1'b1;
                    dec.dest = instr[15:11];
                end else if (instr[20:6] == '0 && fn == FN_JR) begin
                    dec.kind = K_JR;
                end
            end
            default: dec.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/p5_alu.sv
module p5_alu
    import p5_pkg::*;
(
    input  kind_e           kind,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] res
);
    always_comb begin
        case (kind)
            K_LUI:                 res = imm;
            K_ORI:                 res = a | imm;
            K_ADDIU, K_LW, K_SW:   res = a + imm;
            K_AND:                 res = a & b;
            default:               res = '0;
        endcase
    end
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra_dbg,
    output logic [DW-1:0] rd_dbg
);
    localparam int unsigned NREG = 1 << AW;

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    function automatic logic [DW-1:0] read_port(input logic [AW-1:0] ra);
        if (ra == '0)
            return '0;
        else if (we && wa == ra)
            return wd;
        else
            return regs_q[ra];
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (we && wa != '0)
            regs_d[wa] = wd;
        rd_a   = read_port(ra_a);
        rd_b   = read_port(ra_b);
        rd_dbg = regs_q[ra_dbg];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++)
                regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R3: a write aimed at register 0 leaves it zero
    p_reg0_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (we && wa == '0) |=> regs_q[0] == '0);

endmodule

// File: rtl/p5_core.sv
module p5_core
    import p5_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [XLEN-1:0]   imem_rdata,
    output logic [XLEN-1:0]   dmem_addr,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic              dmem_we,
    input  logic [XLEN-1:0]   dmem_rdata,
    input  logic [REG_AW-1:0] dbg_sel,
    output logic [XLEN-1:0]   dbg_data
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    pipe_t           s_q, s_d;
    dec_t            dec;
    logic [XLEN-1:0] rs_val, rt_val, alu_res, target;
    logic            redirect;

    p5_decode u_dec (
        .instr (s_q.fd.instr),
        .dec   (dec)
    );

    p5_regfile #(.DW(XLEN), .AW(REG_AW)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_a   (dec.rs),
        .rd_a   (rs_val),
        .ra_b   (dec.rt),
        .rd_b   (rt_val),
        .we     (s_q.mw.wen),
        .wa     (s_q.mw.dest),
        .wd     (s_q.mw.data),
        .ra_dbg (dbg_sel),
        .rd_dbg (dbg_data)
    );

    p5_alu u_alu (
        .kind (s_q.dx.kind),
        .a    (s_q.dx.a),
        .b    (s_q.dx.b),
        .imm  (s_q.dx.imm),
        .res  (alu_res)
    );

    always_comb begin
        s_d = s_q;

        // register read stage: branches and jumps resolve here
        redirect = (dec.kind == K_JR) || (dec.kind == K_BNE && rs_val != rt_val);
        target   = (dec.kind == K_JR) ? rs_val
                                      : s_q.fd.pc4 + {dec.imm[XLEN-3:0], 2'b00};

        // fetch
        s_d.pc       = redirect ? target : s_q.pc + STEP;
        s_d.fd.instr = imem_rdata;
        s_d.fd.pc4   = s_q.pc + STEP;

        // read -> ALU
        s_d.dx.kind = dec.kind;
        s_d.dx.a    = rs_val;
        s_d.dx.b    = rt_val;
        s_d.dx.imm  = dec.imm;
        s_d.dx.dest = dec.dest;
        s_d.dx.wen  = dec.wen;

        // ALU -> memory
        s_d.xm.kind  = s_q.dx.kind;
        s_d.xm.res   = alu_res;
        s_d.xm.sdata = s_q.dx.b;
        s_d.xm.dest  = s_q.dx.dest;
        s_d.xm.wen   = s_q.dx.wen;

        // memory -> writeback
        s_d.mw.data = (s_q.xm.kind == K_LW) ? dmem_rdata : s_q.xm.res;
        s_d.mw.dest = s_q.xm.dest;
        s_d.mw.wen  = s_q.xm.wen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= '0;
            s_q.pc <= RESET_PC;
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_addr  = s_q.pc;
    assign dmem_addr  = s_q.xm.res;
    assign dmem_wdata = s_q.xm.sdata;
    assign dmem_we    = (s_q.xm.kind == K_SW);

    // R2: sequential fetch advances by one word
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        !redirect |=> imem_addr == $past(imem_addr) + STEP);

    // R9: the word after a branch reaches register read, it is not squashed
    p_delay_slot_kept_r9: assert property (@(posedge clk) disable iff (rst)
        redirect |=> s_q.fd.pc4 == $past(s_q.fd.pc4) + STEP);

    // R4: an upper-immediate load leaves the lower half clear
    p_lui_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
        s_q.dx.kind == K_LUI |=> s_q.xm.res[15:0] == '0);

    // R6: a store leaving the ALU raises the write strobe one cycle later
    p_store_we_r6: assert property (@(posedge clk) disable iff (rst)
        s_q.dx.kind == K_SW |=> dmem_we);

    // R12: nothing is written to data memory right after reset
    p_reset_quiet_r12: assert property (@(posedge clk)
        rst |=> !dmem_we);

endmodule

// File: tb/p5_core_tb.sv
module p5_core_tb;
    localparam int WATCHDOG = 5000;
    localparam int NEXP     = 21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_data;
    logic        dmem_we;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dmem [256];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    p5_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .dbg_sel    (dbg_sel),
        .dbg_data   (dbg_data)
    );

    function automatic logic [31:0] prog(input int idx);
        case (idx)
            0:  return 32'h3C0219FF; // LUI  r2,0x19FF
            1:  return 32'h3C035049; // LUI  r3,0x5049
            2:  return 32'h2404047C; // ADDIU r4,r0,0x47C
            3:  return 32'h3442FF00; // ORI  r2,r2,0xFF00
            4:  return 32'h3463430A; // ORI  r3,r3,0x430A
            5:  return 32'h2405FFFC; // ADDIU r5,r0,-4
            6:  return 32'h00443024; // AND  r6,r2,r4
            7:  return 32'h24070100; // ADDIU r7,r0,0x100
            10: return 32'hACE30004; // SW   r3,4(r7)
            11: return 32'hACE5FFFC; // SW   r5,-4(r7)
            12: return 32'h8CE80004; // LW   r8,4(r7)
            13: return 32'h24090001; // ADDIU r9,r0,1
            16: return 32'h15200002; // BNE  r9,r0,+2 (taken, to 0x4C)
            17: return 32'h240A0011; // delay slot
            18: return 32'h240A0022; // skipped
            19: return 32'h14000005; // BNE  r0,r0 (not taken)
            20: return 32'h240B0007; // delay slot
            21: return 32'h241F0070; // ADDIU r31,r0,0x70
            24: return 32'h03E00008; // JR   r31
            25: return 32'h340D000A; // delay slot ORI r13
            26: return 32'h240E0099; // skipped
            27: return 32'h240E0098; // skipped
            28: return 32'h250F0001; // ADDIU r15,r8,1
            29: return 32'h24000005; // ADDIU r0,r0,5
            30: return 32'h24100003; // ADDIU r16,r0,3
            31: return 32'h26110001; // ADDIU r17,r16,1 (one behind)
            32: return 32'h26120001; // ADDIU r18,r16,1 (two behind)
            33: return 32'h26130001; // ADDIU r19,r16,1 (three behind)
            34: return 32'h3C148000; // LUI  r20,0x8000
            37: return 32'h2695FFFF; // ADDIU r21,r20,-1
            default: return 32'h0;
        endcase
    endfunction

    assign imem_rdata = (imem_addr[31:8] == '0) ? prog(int'(imem_addr[7:2])) : 32'h0;
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk)
        if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

    // {requirement number, register, expected value}
    localparam logic [40:0] EXPV [NEXP] = '{
        {4'd4,  5'd2,  32'h19FFFF00},  // R4
        {4'd4,  5'd3,  32'h5049430A},  // R4
        {4'd5,  5'd4,  32'h0000047C},  // R5
        {4'd5,  5'd5,  32'hFFFFFFFC},  // R5 sign extension
        {4'd5,  5'd6,  32'h00000400},  // R5 AND into rd
        {4'd6,  5'd8,  32'h5049430A},  // R6 load after store
        {4'd7,  5'd9,  32'h00000001},
        {4'd9,  5'd10, 32'h00000011},  // R9 taken-branch slot ran, target skipped one
        {4'd9,  5'd11, 32'h00000007},  // R9 untaken-branch slot
        {4'd8,  5'd31, 32'h00000070},  // R8
        {4'd9,  5'd13, 32'h0000000A},  // R9 jump slot ran
        {4'd8,  5'd14, 32'h00000000},  // R8 jumped-over words did not run
        {4'd6,  5'd15, 32'h5049430B},  // R6
        {4'd3,  5'd0,  32'h00000000},  // R3
        {4'd10, 5'd16, 32'h00000003},
        {4'd10, 5'd17, 32'h00000001},  // R10 one behind: old value
        {4'd10, 5'd18, 32'h00000001},  // R10 two behind: old value
        {4'd10, 5'd19, 32'h00000004},  // R10 three behind: new value
        {4'd4,  5'd20, 32'h80000000},
        {4'd5,  5'd21, 32'h7FFFFFFF},  // R5 wraps, no trap
        {4'd11, 5'd1,  32'h00000000}   // R11 zero words changed nothing
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = '0;
        step(3);
        // R12: reset state
        check("R12", imem_addr, 32'h0);
        check("R12", {31'b0, dmem_we}, 32'h0);
        rst = 1'b0;
        check("R2", imem_addr, 32'h0);
        step(1); check("R2", imem_addr, 32'h4);
        step(1); check("R2", imem_addr, 32'h8);
        dbg_sel = 5'd2;
        step(2); #1 check("R1", dbg_data, 32'h0);
        step(1); #1 check("R1", dbg_data, 32'h19FF0000);
        step(12); check("R9", imem_addr, 32'h44);
        step(1);  check("R7", imem_addr, 32'h4C);
        step(2);  check("R7", imem_addr, 32'h54);
        step(5);  check("R8", imem_addr, 32'h70);
        step(30);
        for (int i = 0; i < NEXP; i++) begin
            dbg_sel = EXPV[i][36:32];
            #1 check($sformatf("R%0d", EXPV[i][40:37]), dbg_data, EXPV[i][31:0]);
        end
        check("R6", dmem[65], 32'h5049430A);
        check("R6", dmem[63], 32'hFFFFFFFC);
        // mid-run reset
        rst = 1'b1;
        step(1);
        check("R12", imem_addr, 32'h0);
        check("R12", {31'b0, dmem_we}, 32'h0);
        dbg_sel = 5'd2;
        #1 check("R12", dbg_data, 32'h0);
        rst = 1'b0;
        step(1); check("R2", imem_addr, 32'h4);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule